// File: doc/BRIEF.md
# Common-Leading-Zero Scaling Normalizer

This block prepares a pair of unsigned magnitudes for an angle evaluator that works from a reciprocal table or a multiplier. The pair is expected to lie in the first octant, with the x magnitude at least as large as the y magnitude. When both operands are small, their quotient falls where the arctangent surface is steep. The block avoids that region by finding the number of leading zero bits the two operands share and shifting both left by that same amount. The normalized x then has its top bit set, so it lies in [1/2, 1), and the quotient y/x and the angle it encodes do not change.

The common count comes from a single priority encoder on the bitwise OR of the two operands. One pipeline register separates that encoder from a pair of logarithmic barrel shifters, and a second register holds the results. One new pair can enter on every clock. Results appear two cycles after their inputs. If both operands are zero, a flag is raised, the count saturates at the operand width and both outputs are zero.

Top module: `normScaler`

## Requirements
- R1: While reset is active and in the first cycle after it, outValid, outX, outY, outShift and outZero are all zero.
- R2: A pair accepted with inValid high in one clock cycle produces outValid high exactly two cycles later. Back-to-back pairs yield back-to-back results.
- R3: For a pair that is not all zero, outShift equals the number of leading zero bits of (inX OR inY), counted from bit WIDTH-1 downward. Its value lies between 0 and WIDTH-1.
- R4: For a pair that is not all zero, outX equals inX shifted left by outShift, and outY equals inY shifted left by outShift, both in WIDTH bits.
- R5: For a pair that is not all zero, bit WIDTH-1 of (outX OR outY) is set. When inX is greater than or equal to inY, this is the top bit of outX.
- R6: The number of set bits in outY equals the number of set bits in inY, so no set bit of y is shifted out.
- R7: For an all-zero pair, outZero is 1, outShift equals WIDTH, and outX and outY are 0. For any other pair, outZero is 0.
- R8: While outValid is low, outX, outY, outShift and outZero keep the values of the last result.
- R9: A pair outside the octant (inY greater than inX) still receives the shared count and shift of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input pair is present this cycle |
| inX | input | WIDTH | Unsigned magnitude of x |
| inY | input | WIDTH | Unsigned magnitude of y |
| outValid | output | 1 | Normalized result is present |
| outX | output | WIDTH | x shifted left by the shared count |
| outY | output | WIDTH | y shifted left by the shared count |
| outShift | output | $clog2(WIDTH+1) | Shared leading-zero count |
| outZero | output | 1 | Both inputs were zero |

## Verification
The assertions check on every cycle the properties that can be read from the outputs alone:
- the two-cycle valid latency;
- a top bit set in the OR of the normalized pair;
- a count below WIDTH for any pair that is not all zero;
- the saturated count and zero outputs for an all-zero pair;
- result registers that stay still between results.

Whether the count is the true number of shared leading zeros, whether each output is exactly its input shifted, and whether the set bits of y survive all depend on inputs from two cycles earlier. Only the bench can show these. Its reference model tracks every pair, including pairs outside the octant, single-bit operands at both ends of the width, and runs broken by idle gaps.

// File: rtl/normPkg.sv
package normPkg;
  // Load strobes sent from the control to the datapath
  typedef struct packed {
    logic loadStage1;   // capture operands and shared count
    logic loadStage2;   // capture shifted results
  } normStrobe_t;
endpackage

// File: rtl/normLzc.sv
// Priority encoder: leading zeros of a vector, saturating at WIDTH
module normLzc #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count,
  output logic             allZero
);
  always_comb begin
    count = CNT_W'(WIDTH);
    // higher set bits override lower ones
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) count = CNT_W'(WIDTH - 1 - i);
    end
  end

  assign allZero = (vec == '0);
endmodule

// File: rtl/normShifter.sv
// Logarithmic left shifter: one 2:1 multiplexer stage per count bit
module normShifter #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [CNT_W-1:0] amount,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] stage [0:CNT_W];

  assign stage[0] = dataIn;

  for (genvar j = 0; j < CNT_W; j++) begin : g_stage
    localparam int STEP = 1 << j;
    assign stage[j+1] = amount[j] ? (stage[j] << STEP) : stage[j];
  end

  assign dataOut = stage[CNT_W];
endmodule

// File: rtl/normCtrl.sv
// Valid pipeline; drives the datapath load strobes
module normCtrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output normPkg::normStrobe_t strobe,
  output logic                outValid
);
  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadStage1 = inValid;
    strobe.loadStage2 = stage1Valid;
  end
endmodule

// File: rtl/normDatapath.sv
// Count stage, pipeline register, shift stage, result register
module normDatapath #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  normPkg::normStrobe_t strobe,
  input  logic [WIDTH-1:0]     inX,
  input  logic [WIDTH-1:0]     inY,
  output logic [WIDTH-1:0]     outX,
  output logic [WIDTH-1:0]     outY,
  output logic [CNT_W-1:0]     outShift,
  output logic                 outZero
);
  logic [WIDTH-1:0] orVec;
  logic [CNT_W-1:0] lzCount;
  logic             lzZero;
  logic [WIDTH-1:0] s1X, s1Y;
  logic [CNT_W-1:0] s1Shift;
  logic             s1Zero;
  logic [WIDTH-1:0] shX, shY;

  assign orVec = inX | inY;

  normLzc #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uLzc (
    .vec(orVec), .count(lzCount), .allZero(lzZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1X     <= '0;
      s1Y     <= '0;
      s1Shift <= '0;
      s1Zero  <= 1'b0;
    end else if (strobe.loadStage1) begin
      s1X     <= inX;
      s1Y     <= inY;
      s1Shift <= lzCount;
      s1Zero  <= lzZero;
    end
  end

  normShifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uShiftX (
    .dataIn(s1X), .amount(s1Shift), .dataOut(shX)
  );
  normShifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uShiftY (
    .dataIn(s1Y), .amount(s1Shift), .dataOut(shY)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outX     <= '0;
      outY     <= '0;
      outShift <= '0;
      outZero  <= 1'b0;
    end else if (strobe.loadStage2) begin
      outX     <= shX;
      outY     <= shY;
      outShift <= s1Shift;
      outZero  <= s1Zero;
    end
  end
endmodule

// File: rtl/normScaler.sv
module normScaler #(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inX,
  input  logic [WIDTH-1:0] inY,
  output logic             outValid,
  output logic [WIDTH-1:0] outX,
  output logic [WIDTH-1:0] outY,
  output logic [CNT_W-1:0] outShift,
  output logic             outZero
);
  normPkg::normStrobe_t strobe;

  normCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  normDatapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inX(inX), .inY(inY),
    .outX(outX), .outY(outY), .outShift(outShift), .outZero(outZero)
  );
endmodule

// File: rtl/normScaler_chk.sv
module normScaler_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             outValid,
  input logic [WIDTH-1:0] outX,
  input logic [WIDTH-1:0] outY,
  input logic [CNT_W-1:0] outShift,
  input logic             outZero
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  assert_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outZero) |-> (outShift < CNT_W'(WIDTH)));

  assert_msb_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outZero) |-> ((outX | outY) >> (WIDTH - 1)) == 1);

  assert_zero_case_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outZero) |-> (outX == '0 && outY == '0 && outShift == CNT_W'(WIDTH)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outX) && $stable(outY) && $stable(outShift) && $stable(outZero)));
endmodule

bind normScaler normScaler_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outX(outX), .outY(outY), .outShift(outShift), .outZero(outZero)
);

// File: tb/normScaler_test.sv
`timescale 1ns/1ps
module normScaler_test;
  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic [W-1:0] inX, inY;
  logic outValid;
  logic [W-1:0] outX, outY;
  logic [CW-1:0] outShift;
  logic outZero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  normScaler #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX), .inY(inY),
    .outValid(outValid), .outX(outX), .outY(outY),
    .outShift(outShift), .outZero(outZero)
  );

  function automatic int leadZeros(logic [W-1:0] v);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  // Behavioural reference: two-cycle pipeline, results held between valids
  logic mdl1V, mdl2V;
  logic [W-1:0] mdl1X, mdl1Y;
  logic [W-1:0] expX, expY, expYin;
  logic [CW-1:0] expS;
  logic expZ;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdl1V = 0; mdl2V = 0; mdl1X = '0; mdl1Y = '0;
      expX = '0; expY = '0; expYin = '0; expS = '0; expZ = 0;
    end else begin
      mdl2V = mdl1V;
      if (mdl1V) begin
        expS   = CW'(leadZeros(mdl1X | mdl1Y));
        expZ   = ((mdl1X | mdl1Y) == '0);
        expX   = mdl1X << expS;
        expY   = mdl1Y << expS;
        expYin = mdl1Y;
      end
      mdl1V = inValid;
      if (inValid) begin
        mdl1X = inX;
        mdl1Y = inY;
      end
    end
  end

  task automatic report(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkCycle();
    string tagData, tagShift;
    tagData  = !mdl2V ? "R8" : (expZ ? "R7" : "R4");
    tagShift = !mdl2V ? "R8" : (expZ ? "R7" : "R3");
    report("R2", "outValid", 32'(outValid), 32'(mdl2V));
    report(tagShift, "outShift", 32'(outShift), 32'(expS));
    report(tagData, "outX", 32'(outX), 32'(expX));
    report(tagData, "outY", 32'(outY), 32'(expY));
    report(!mdl2V ? "R8" : "R7", "outZero", 32'(outZero), 32'(expZ));
    if (mdl2V && !expZ) begin
      report("R5", "top bit of outX|outY", 32'((outX | outY) >> (W - 1)), 32'd1);
      report("R6", "set bits of outY", 32'($countones(outY)), 32'($countones(expYin)));
    end
  endtask

  task automatic drive(logic v, logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    checkCycle();
    inValid = v;
    inX = x;
    inY = y;
  endtask

  initial begin
    logic [31:0] lfsr;
    rstN = 0; inValid = 0; inX = '0; inY = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    report("R1", "outValid in reset", 32'(outValid), 0);
    report("R1", "outX in reset", 32'(outX), 0);
    report("R1", "outY in reset", 32'(outY), 0);
    report("R1", "outShift in reset", 32'(outShift), 0);
    report("R1", "outZero in reset", 32'(outZero), 0);
    rstN = 1;
    @(negedge clk);
    report("R1", "outValid after reset", 32'(outValid), 0);

    // Directed pairs (R3, R4, R5, R7, R9)
    drive(1, 16'h8000, 16'h1234);   // already normalized, s=0
    drive(1, 16'h0001, 16'h0000);   // s=15
    drive(1, 16'h0001, 16'h0001);
    drive(1, 16'h0000, 16'h0000);   // R7 zero pair
    drive(1, 16'h00F0, 16'h0030);   // s=8
    drive(0, 16'hFFFF, 16'hFFFF);   // idle, R8 hold
    drive(0, 16'h0000, 16'h0000);
    drive(0, 16'h0000, 16'h0000);
    drive(1, 16'h0001, 16'h0100);   // R9 y above x, s=7
    drive(1, 16'h4000, 16'h3FFF);   // s=1
    drive(1, 16'h0000, 16'h0000);   // zero back-to-back
    drive(1, 16'h0003, 16'h0002);   // s=14

    // Random octant pairs with gaps (R2 throughput)
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, b, t;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr[15:0] >> lfsr[19:16];
      b = lfsr[31:16] >> lfsr[19:16];
      if (b > a && lfsr[20]) begin t = a; a = b; b = t; end
      drive(lfsr[23:21] != 3'b000, a, b);
    end
    repeat (4) drive(0, '0, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule